// File: doc/BRIEF.md
# Daisy-Chain Three-Wire Potentiometer Host

This block drives a string of serially chained digital potentiometer devices from the host side of a three-wire bus. The bus has an enable line, a serial clock and a data line. Each device holds a 17-bit word: a select bit that picks which of its two wipers reaches the combined output, and two 8-bit wiper settings. A client gives a one-cycle start, a read/write flag and a parallel frame of 17 bits per device. The block then raises the enable, clocks the whole frame and lowers the enable. It waits out the required idle time and pulses done, presenting the frame it collected from the chain's return line.

In write mode the frame is driven onto the data line. In read mode the output driver is switched off, so the chain's return line can feed back into its own input. The block clocks the chain exactly once around, which leaves every device holding the value it had before. Bus timing comes from the system clock. Each minimum is a nanosecond parameter that is turned into whole cycles by rounding up.

Top module: `tri_wire_chain_host`

## Requirements
- R1: After reset, enable, serial clock, data, output-enable, busy and done are all low and the reported frame is zero.
- R2: Every transaction produces exactly 17·N_DEV rising serial-clock edges.
- R3: The frame is sent from bit 17·N_DEV−1 down to bit 0. The slice at bits [17d+16:17d] belongs to device d, where device 0 is nearest the host, so the farthest device's slice goes first. Inside a slice, bit 16 is the select bit, bits 15:8 are wiper 1 and bits 7:0 are wiper 0, each sent MSB first.
- R4: The first rising clock edge comes exactly ceil(SETUP_NS/Tclk) system cycles after the enable rises.
- R5: Each serial-clock high phase lasts ceil(PHASE_NS/Tclk) cycles, and each low phase between rising edges lasts the same count.
- R6: The data line changes only while the serial clock is low, and never in the cycle in which the clock rises.
- R7: The enable falls ceil(PHASE_NS/Tclk)+ceil(HOLD_NS/Tclk) cycles after the last rising clock edge, with the clock already low.
- R8: Done pulses exactly ceil(GAP_NS/Tclk) cycles after the enable falls. The enable never rises again sooner than that gap plus one cycle.
- R9: In read mode the output-enable stays low for the whole transaction. The returned bits are captured at each rising edge into the reported frame in the R3 order, and the chain ends holding its original contents.
- R10: A start that arrives while busy is ignored, and the frame, mode and bit count of the running transaction do not change.
- R11: Busy is high from the cycle after an accepted start until the cycle in which done pulses. Done lasts one cycle.
- R12: The serial clock is high only while the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a transaction |
| read_i | input | 1 | 1 = circular readback, 0 = write; sampled with start_i |
| frame_i | input | 17·N_DEV | Frame to write, in the R3 layout |
| sdi_i | input | 1 | Return bit from the last device of the chain |
| sen_o | output | 1 | Bus enable, active high |
| sclk_o | output | 1 | Serial clock; devices sample on its rising edge |
| sdo_o | output | 1 | Serial data toward the first device |
| sdo_oe_o | output | 1 | Driver enable for sdo_o; low during reads |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| frame_o | output | 17·N_DEV | Frame captured from sdi_i in the last transaction |

## Verification
The bench builds the block with two chained devices and a 125 MHz system clock. Those values give 7 cycles of enable lead, 18-cycle clock phases, a 7-cycle tail and a 16-cycle idle gap. Two devices give a 34-bit frame. A single walking one can therefore be swept through every bit position, and every slice boundary is crossed, including the one between the farther and the nearer device. A bit-level model of the chain recirculates the return line into the data line whenever the driver is off. This lets the bench check both the written contents and the non-destructive readback.

// File: rtl/twch_pkg.sv
package twch_pkg;

    localparam int SLICE_W = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_REST
    } seq_state_t;

    typedef struct packed {
        logic sen;
        logic sclk;
        logic rd;
        logic busy;
        logic done;
    } bus_ctl_t;

    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/twch_phase_timer.sv
module twch_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // The count never wraps: once it is at zero it stays there until reloaded (R5).
    assert_timer_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/twch_shift_unit.sv
module twch_shift_unit #(
    parameter int FRAME_W = 34
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               advance,
    input  logic               capture,
    input  logic               sdi,
    output logic               tx_bit,
    output logic [FRAME_W-1:0] rx_frame,
    output logic               rises_done
);
    localparam int LEFT_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;
    logic [LEFT_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            left_q <= '0;
        end else begin
            if (load) begin
                tx_q   <= frame_in;
                rx_q   <= '0;
                left_q <= LEFT_W'(FRAME_W);
            end else begin
                if (advance) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
                if (capture) begin
                    rx_q   <= {rx_q[FRAME_W-2:0], sdi};
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

    assign tx_bit     = tx_q[FRAME_W-1];
    assign rx_frame   = rx_q;
    assign rises_done = (left_q == '0);

    // A capture beyond the frame length would be an extra rising edge (R2).
    assert_no_extra_rise_R2: assert property (@(posedge clk) disable iff (rst)
        capture |-> (left_q != '0));
    // Shifting and capturing never coincide: data moves only on the falling side (R6).
    assert_shift_apart_R6: assert property (@(posedge clk) disable iff (rst)
        !(advance && capture));
endmodule

// File: rtl/tri_wire_chain_host.sv
module tri_wire_chain_host
    import twch_pkg::*;
#(
    parameter int N_DEV    = 2,
    parameter int CLK_PS   = 8000,
    parameter int SETUP_NS = 50,
    parameter int PHASE_NS = 143,
    parameter int HOLD_NS  = 50,
    parameter int GAP_NS   = 125
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     read_i,
    input  logic [SLICE_W*N_DEV-1:0] frame_i,
    input  logic                     sdi_i,
    output logic                     sen_o,
    output logic                     sclk_o,
    output logic                     sdo_o,
    output logic                     sdo_oe_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [SLICE_W*N_DEV-1:0] frame_o
);
    localparam int FRAME_W = SLICE_W * N_DEV;
    localparam int C_SETUP = ns_to_cycles(SETUP_NS, CLK_PS);
    localparam int C_PHASE = ns_to_cycles(PHASE_NS, CLK_PS);
    localparam int C_HOLD  = ns_to_cycles(HOLD_NS, CLK_PS);
    localparam int C_GAP   = ns_to_cycles(GAP_NS, CLK_PS);
    localparam int C_MAX   = max_of4(C_SETUP, C_PHASE, C_HOLD, C_GAP);
    localparam int CNT_W   = (C_MAX < 2) ? 1 : $clog2(C_MAX);

    seq_state_t st_q, st_n;
    bus_ctl_t   ctl_q, ctl_n;
    logic [FRAME_W-1:0] frame_q;

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_exp;
    logic             sh_load, sh_adv, sh_cap, sh_tx, sh_end;
    logic [FRAME_W-1:0] sh_rx;
    logic             fr_upd;

    twch_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    twch_shift_unit #(.FRAME_W(FRAME_W)) shift_i (
        .clk(clk), .rst(rst), .load(sh_load), .frame_in(frame_i),
        .advance(sh_adv), .capture(sh_cap), .sdi(sdi_i),
        .tx_bit(sh_tx), .rx_frame(sh_rx), .rises_done(sh_end)
    );

    always_comb begin
        st_n     = st_q;
        ctl_n    = ctl_q;
        ctl_n.done = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        sh_cap   = 1'b0;
        fr_upd   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    sh_load    = 1'b1;
                    ctl_n.rd   = read_i;
                    ctl_n.sen  = 1'b1;
                    ctl_n.busy = 1'b1;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(C_SETUP - 1);
                    st_n       = ST_LEAD;
                end
            end
            ST_LEAD, ST_LOW: begin
                if (t_exp) begin
                    ctl_n.sclk = 1'b1;
                    sh_cap     = 1'b1;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(C_PHASE - 1);
                    st_n       = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (t_exp) begin
                    ctl_n.sclk = 1'b0;
                    t_load     = 1'b1;
                    if (sh_end) begin
                        t_val = CNT_W'(C_HOLD - 1);
                        st_n  = ST_TAIL;
                    end else begin
                        sh_adv = 1'b1;
                        t_val  = CNT_W'(C_PHASE - 1);
                        st_n   = ST_LOW;
                    end
                end
            end
            ST_TAIL: begin
                if (t_exp) begin
                    ctl_n.sen = 1'b0;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(C_GAP - 1);
                    st_n      = ST_REST;
                end
            end
            ST_REST: begin
                if (t_exp) begin
                    ctl_n.done = 1'b1;
                    ctl_n.busy = 1'b0;
                    fr_upd     = 1'b1;
                    st_n       = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ctl_q   <= '0;
            frame_q <= '0;
        end else begin
            st_q  <= st_n;
            ctl_q <= ctl_n;
            if (fr_upd) frame_q <= sh_rx;
        end
    end

    assign sen_o    = ctl_q.sen;
    assign sclk_o   = ctl_q.sclk;
    assign busy_o   = ctl_q.busy;
    assign done_o   = ctl_q.done;
    assign sdo_oe_o = ctl_q.sen & ~ctl_q.rd;
    assign sdo_o    = sdo_oe_o & sh_tx;
    assign frame_o  = frame_q;

    assert_clk_inside_en_R12: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> sen_o);
    assert_read_undriven_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ctl_q.rd) |-> !sdo_oe_o);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_ends_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !sen_o));
    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (ctl_q.rd == $past(ctl_q.rd)));
    assert_en_drop_clock_low_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(sen_o) |-> !sclk_o);
endmodule

// File: tb/tri_wire_chain_host_tb.sv
module tri_wire_chain_host_tb_top;
    localparam int N    = 2;
    localparam int W    = 17 * N;
    localparam int TPS  = 8000;
    localparam int S    = (50 * 1000 + TPS - 1) / TPS;
    localparam int PH   = (143 * 1000 + TPS - 1) / TPS;
    localparam int HOLD = (50 * 1000 + TPS - 1) / TPS;
    localparam int GAP  = (125 * 1000 + TPS - 1) / TPS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic read_i = 1'b0;
    logic [W-1:0] frame_i = '0;
    logic sdi_i;
    logic sen_o, sclk_o, sdo_o, sdo_oe_o, busy_o, done_o;
    logic [W-1:0] frame_o;

    always #4 clk = ~clk;

    tri_wire_chain_host #(.N_DEV(N)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .read_i(read_i),
        .frame_i(frame_i), .sdi_i(sdi_i), .sen_o(sen_o), .sclk_o(sclk_o),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .busy_o(busy_o),
        .done_o(done_o), .frame_o(frame_o)
    );

    // Chain model: device 0 nearest the host; the top bit feeds back on the return line.
    logic [W-1:0] chain = '0;
    logic dq;
    assign sdi_i = chain[W-1];
    assign dq = sdo_oe_o ? sdo_o : chain[W-1];
    always @(posedge sclk_o) chain <= {chain[W-2:0], dq};

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    int cyc = 0, t_en = 0, t_rise = 0, t_cf = 0, t_fall = 0, rises = 0;
    bit first = 0, have_fall = 0, rd_cur = 0;
    logic psen = 0, psclk = 0, psdo = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (sen_o && !psen) begin
                if (have_fall) chk(cyc - t_fall >= GAP + 1, "R8 enable relaunch gap", cyc - t_fall, GAP + 1);
                t_en = cyc; rises = 0; first = 1;
            end
            if (sclk_o && !psclk) begin
                chk(sen_o, "R12 clock inside enable", sen_o, 1);
                if (first) chk(cyc - t_en == S, "R4 enable to first rise", cyc - t_en, S);
                else       chk(cyc - t_cf == PH, "R5 low phase", cyc - t_cf, PH);
                chk(sdo_o == psdo, "R6 data moved at rise", sdo_o, psdo);
                first = 0; rises++; t_rise = cyc;
            end
            if (!sclk_o && psclk) begin
                chk(cyc - t_rise == PH, "R5 high phase", cyc - t_rise, PH);
                t_cf = cyc;
            end
            if (sclk_o && psclk && sdo_o != psdo) chk(0, "R6 data moved while high", sdo_o, psdo);
            if (!sen_o && psen) begin
                chk(rises == W, "R2 rising edge count", rises, W);
                chk(cyc - t_rise == PH + HOLD, "R7 last rise to enable low", cyc - t_rise, PH + HOLD);
                chk(!sclk_o, "R7 clock low at enable fall", sclk_o, 0);
                t_fall = cyc; have_fall = 1;
            end
            if (done_o) begin
                chk(cyc - t_fall == GAP, "R8 done after idle gap", cyc - t_fall, GAP);
                chk(!busy_o, "R11 busy clears with done", busy_o, 0);
            end
            if (rd_cur && sdo_oe_o) chk(0, "R9 driver on during read", sdo_oe_o, 0);
        end
        psen = sen_o; psclk = sclk_o; psdo = sdo_o;
    end

    task automatic run(input bit rd, input logic [W-1:0] fr);
        @(negedge clk);
        rd_cur = rd; read_i = rd; frame_i = fr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R11 busy after start", busy_o, 1);
        while (!done_o) @(negedge clk);
        chk(!done_o || 1'b1, "R11 done seen", 1, 1);
        @(negedge clk);
        chk(!done_o, "R11 done one cycle", done_o, 0);
        rd_cur = 0;
    endtask

    function automatic logic [W-1:0] build(input int k);
        logic [W-1:0] f;
        f = '0;
        for (int d = 0; d < N; d++) begin
            f[17*d+16]        = 1'((k + d) & 1);
            f[17*d+8 +: 8]    = 8'((k * 37 + d * 11) & 255);
            f[17*d +: 8]      = 8'((k * 91 + d * 53 + 7) & 255);
        end
        return f;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({sen_o, sclk_o, sdo_o, sdo_oe_o, busy_o, done_o} == 6'b0, "R1 reset outputs",
            {sen_o, sclk_o, sdo_o, sdo_oe_o, busy_o, done_o}, 0);
        chk(frame_o == '0, "R1 reset frame", frame_o, 0);

        // R3: walking one through every frame position
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] f;
            f = '0; f[k] = 1'b1;
            run(1'b0, f);
            chk(chain == f, "R3 walking one landed", chain, f);
        end

        // R3: field-level placement per device
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] f;
            f = build(k);
            run(1'b0, f);
            for (int d = 0; d < N; d++) begin
                chk(chain[17*d+16] == 1'((k + d) & 1), "R3 select bit", chain[17*d+16], (k + d) & 1);
                chk(chain[17*d+8 +: 8] == 8'((k * 37 + d * 11) & 255), "R3 wiper 1",
                    chain[17*d+8 +: 8], (k * 37 + d * 11) & 255);
                chk(chain[17*d +: 8] == 8'((k * 91 + d * 53 + 7) & 255), "R3 wiper 0",
                    chain[17*d +: 8], (k * 91 + d * 53 + 7) & 255);
            end
            // R9: readback returns contents and leaves them in place
            run(1'b1, ~f);
            chk(frame_o == f, "R9 captured frame", frame_o, f);
            chk(chain == f, "R9 chain unchanged", chain, f);
        end

        // R10: second start while busy is ignored
        begin
            logic [W-1:0] a, b;
            a = build(9); b = ~a;
            @(negedge clk);
            rd_cur = 0; read_i = 1'b0; frame_i = a; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (100) @(negedge clk);
            read_i = 1'b1; frame_i = b; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o, "R10 still busy", busy_o, 1);
            while (!done_o) @(negedge clk);
            @(negedge clk);
            chk(chain == a, "R10 first frame kept", chain, a);
            chk(!sen_o && !busy_o, "R10 no relaunch", sen_o, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule